// File: doc/BRIEF.md
# Register-Controlled Single-Channel Pulse-Width Modulator

This block drives one pulse-width modulated output pin from a single 32-bit control word. The word is accessed over a minimal bus: a select strobe, a write enable, write data and read data. A programmable prescaler divides the peripheral clock. Each prescaled tick advances an 8-bit phase counter, so every output period is exactly 256 ticks long.

An 8-bit compare field sets the number of ticks at the start of each period during which the pin is held low. The pin is driven high for the remaining ticks of the period. When the channel is switched off, a separate bit of the word selects the constant level on the pin. New divisor and compare values are staged internally and only take effect at the next period boundary, so the waveform never contains a shortened or malformed period. Software that wants to change one field without touching the others reads the word, modifies it and writes it back.

Top module: `pwm_single_top`

## Requirements
- R1: After synchronous reset the control word reads 0x00000000 and the output pin is low.
- R2: A write takes place on a rising clock edge where select and write enable are both high. From the next cycle on, read data returns the whole word: bit 31 enable, bit 30 idle level, bits 15:8 divisor, bits 7:0 compare. Bits 29:16 always read zero and written values there are ignored.
- R3: While bit 31 is clear, the output pin equals bit 30.
- R4: A divisor field of 1 to 255 divides the input clock by that value. A divisor field of 0 divides by 256.
- R5: While enabled, one output period lasts 256 times the effective divisor, in input clock cycles.
- R6: Each period starts low. The pin stays low for compare × divisor cycles, then stays high for (256 − compare) × divisor cycles, for compare values 1 to 255.
- R7: Divisor and compare values written during a period leave that period unchanged and govern the periods that follow it.
- R8: After bit 31 is cleared by a write, the pin shows the bit-30 level from the second clock edge after the write onward.
- R9: When bit 31 is set, a fresh period begins at phase 0 on the clock edge after the write. The pin first goes high compare × divisor cycles after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Word strobe selecting the control word |
| bus_we | input | 1 | Write enable, qualified by bus_sel |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Current control word |
| pwm_out | output | 1 | Modulated output pin |

## Verification
Read data is due in the first cycle after the write edge. An enable is due two edges after its write, because the write edge loads the word and the following edge starts the period. Disabling shows the idle level after the second edge. The bench drives inputs and samples on falling edges, and every write task returns at a known falling edge. The bench then counts falling-edge samples between rising transitions of the pin to measure period and high time, and compares them with 256 × divisor and (256 − compare) × divisor. For the enable latency it counts samples from the write until the first high sample and expects 1 + compare × divisor. For a mid-period update the expected interval is the rest of the old period plus the low phase of the new setting.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int WORD_W   = 32;
    localparam int FIELD_W  = 8;
    localparam int PHASES   = 1 << FIELD_W;
    localparam int EDIV_W   = FIELD_W + 1;
    localparam int EN_POS   = 31;
    localparam int IDLE_POS = 30;
    localparam logic [WORD_W-1:0] LIVE_MASK = 32'hC000_FFFF;

    typedef struct packed {
        logic               en;
        logic               idle;
        logic [FIELD_W-1:0] div;
        logic [FIELD_W-1:0] cmp;
    } ctrl_t;

    function automatic logic [EDIV_W-1:0] eff_div(input logic [FIELD_W-1:0] f);
        return (f == '0) ? EDIV_W'(PHASES) : {1'b0, f};
    endfunction

    function automatic logic [WORD_W-1:0] to_word(input ctrl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[EN_POS]              = c.en;
        w[IDLE_POS]            = c.idle;
        w[2*FIELD_W-1:FIELD_W] = c.div;
        w[FIELD_W-1:0]         = c.cmp;
        return w;
    endfunction

    function automatic ctrl_t from_word(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.en   = w[EN_POS];
        c.idle = w[IDLE_POS];
        c.div  = w[2*FIELD_W-1:FIELD_W];
        c.cmp  = w[FIELD_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/pwm_ctrl_reg.sv
module pwm_ctrl_reg
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output ctrl_t             ctrl
);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (sel && we) begin
            ctrl_q <= from_word(wdata);
        end
    end

    assign ctrl  = ctrl_q;
    assign rdata = to_word(ctrl_q);

    // R2: a write is visible in full on the next cycle, reserved bits dropped
    a_r2_write_readback: assert property (@(posedge clk) disable iff (rst)
        (sel && we) |=> (rdata == ($past(wdata) & LIVE_MASK)));

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [EDIV_W-1:0] div_eff,
    output logic              tick
);

    logic [FIELD_W-1:0] cnt_q;
    logic               last;

    assign last = ({1'b0, cnt_q} == (div_eff - EDIV_W'(1)));
    assign tick = run && last;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + FIELD_W'(1);
        end
    end

    // R4: the prescale count never reaches the effective divisor
    a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        run |-> ({1'b0, cnt_q} < div_eff));

endmodule

// File: rtl/pwm_sequencer.sv
module pwm_sequencer
    import pwm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  ctrl_t              ctrl,
    input  logic               tick,
    output logic               run,
    output logic [EDIV_W-1:0]  div_eff,
    output logic [FIELD_W-1:0] phase,
    output logic [FIELD_W-1:0] cmp_act
);

    logic               run_q;
    logic [FIELD_W-1:0] phase_q;
    logic [FIELD_W-1:0] div_sh;
    logic [FIELD_W-1:0] cmp_sh;
    logic               wrap;

    assign wrap = tick && (phase_q == FIELD_W'(PHASES - 1));

    always_ff @(posedge clk) begin
        if (rst || !ctrl.en) begin
            run_q   <= 1'b0;
            phase_q <= '0;
            div_sh  <= '0;
            cmp_sh  <= '0;
        end else if (!run_q) begin
            run_q   <= 1'b1;
            phase_q <= '0;
            div_sh  <= ctrl.div;
            cmp_sh  <= ctrl.cmp;
        end else if (tick) begin
            phase_q <= phase_q + FIELD_W'(1);
            if (wrap) begin
                div_sh <= ctrl.div;
                cmp_sh <= ctrl.cmp;
            end
        end
    end

    assign run     = run_q;
    assign div_eff = eff_div(div_sh);
    assign phase   = phase_q;
    assign cmp_act = cmp_sh;

    // R7: staged settings only change at a period boundary
    a_r7_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q) && !$past(wrap)) |-> ($stable(cmp_sh) && $stable(div_sh)));

    // R5: the phase only advances on a prescaled tick
    a_r5_phase_hold: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q) && !$past(tick)) |-> $stable(phase_q));

endmodule

// File: rtl/pwm_single_top.sv
module pwm_single_top
    import pwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        pwm_out
);

    ctrl_t              ctrl;
    logic               run;
    logic               tick;
    logic [EDIV_W-1:0]  div_eff;
    logic [FIELD_W-1:0] phase;
    logic [FIELD_W-1:0] cmp_act;

    pwm_ctrl_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .sel   (bus_sel),
        .we    (bus_we),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .ctrl  (ctrl)
    );

    pwm_sequencer u_seq (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl),
        .tick    (tick),
        .run     (run),
        .div_eff (div_eff),
        .phase   (phase),
        .cmp_act (cmp_act)
    );

    pwm_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .div_eff (div_eff),
        .tick    (tick)
    );

    assign pwm_out = run ? (phase >= cmp_act) : ctrl.idle;

    // R3 / R8: one edge after enable is low, the pin shows the idle level
    a_r8_idle_level: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en |=> (pwm_out == ctrl.idle));

    // R1: reset leaves the word clear and the pin low
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (bus_rdata == '0 && !pwm_out));

endmodule

// File: tb/test_pwm_single_top.sv
module test_pwm_single_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 195000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    pwm_single_top i_pwm_single_top (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("FAIL watchdog: run hung, cycles %0d expected below %0d", cycles, WATCHDOG);
            summary();
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks = n_checks + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d (0x%08h) expected %0d (0x%08h)", req, act, act, exp, exp);
        end
    endtask

    function automatic logic [31:0] word(input bit en, input bit idle, input int d, input int c);
        return {en, idle, 14'b0, 8'(d), 8'(c)};
    endfunction

    task automatic bus_write(input logic [31:0] w);
        bus_sel   = 1'b1;
        bus_we    = 1'b1;
        bus_wdata = w;
        @(negedge clk);
        bus_sel   = 1'b0;
        bus_we    = 1'b0;
    endtask

    task automatic wait_rise();
        bit prev;
        prev = pwm_out;
        forever begin
            @(negedge clk);
            if (pwm_out && !prev) break;
            prev = pwm_out;
        end
    endtask

    // Called at a negedge where the pin has just gone high
    task automatic measure(output int per, output int hi);
        bit prev;
        per  = 0;
        hi   = 0;
        prev = 1'b1;
        forever begin
            if (pwm_out) hi++;
            per++;
            @(negedge clk);
            if (pwm_out && !prev) break;
            prev = pwm_out;
        end
    endtask

    initial begin
        int per;
        int hi;
        int k;
        int dvals[4] = '{1, 2, 3, 5};
        int cvals[3] = '{1, 100, 255};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 reset word", int'(bus_rdata), 0);
        check("R1 reset pin", int'(pwm_out), 0);

        // R2 + R3: reserved bits ignored, idle level high while disabled
        bus_write(32'h7FFF_1234);
        check("R2 readback reserved zero", int'(bus_rdata), int'(32'h4000_1234));
        check("R3 idle high", int'(pwm_out), 1);
        repeat (20) @(negedge clk);
        check("R3 idle high held", int'(pwm_out), 1);
        bus_write(word(0, 0, 7, 9));
        check("R2 readback fields", int'(bus_rdata), int'(word(0, 0, 7, 9)));
        check("R3 idle low", int'(pwm_out), 0);

        // R4 R5 R6: sweep of divisors and compare values
        foreach (dvals[i]) begin
            foreach (cvals[j]) begin
                bus_write(word(0, 0, dvals[i], cvals[j]));
                bus_write(word(1, 0, dvals[i], cvals[j]));
                wait_rise();
                measure(per, hi);
                check($sformatf("R5 period d=%0d c=%0d", dvals[i], cvals[j]), per, 256 * dvals[i]);
                check($sformatf("R6 high d=%0d c=%0d", dvals[i], cvals[j]), hi, (256 - cvals[j]) * dvals[i]);
            end
        end

        // R8: disable while running goes to idle level on the second edge
        bus_write(word(0, 1, 1, 1));
        @(negedge clk);
        check("R8 idle 1 after disable", int'(pwm_out), 1);
        bus_write(word(1, 1, 1, 1));
        wait_rise();
        bus_write(word(0, 0, 1, 1));
        @(negedge clk);
        check("R8 idle 0 after disable", int'(pwm_out), 0);

        // R9: fresh period after enable, first rise after 1 + c*d samples
        bus_write(word(1, 0, 3, 10));
        k = 0;
        while (!pwm_out && k < 2000) begin
            @(negedge clk);
            k++;
        end
        check("R9 first rise latency", k, 1 + 10 * 3);

        // R7: update in mid-period applies at the next boundary
        bus_write(word(0, 0, 2, 64));
        bus_write(word(1, 0, 2, 64));
        wait_rise();
        bus_sel   = 1'b1;
        bus_we    = 1'b1;
        bus_wdata = word(1, 0, 1, 200);
        measure(per, hi);
        bus_sel   = 1'b0;
        bus_we    = 1'b0;
        check("R7 old period tail + new low", per, 192 * 2 + 200);
        check("R7 old period high kept", hi, 192 * 2);
        measure(per, hi);
        check("R7 new period length", per, 256);
        check("R7 new period high", hi, 56);

        // R4: divisor field 0 means divide by 256
        bus_write(word(0, 0, 0, 1));
        bus_write(word(1, 0, 0, 1));
        wait_rise();
        measure(per, hi);
        check("R4 divisor 0 period", per, 65536);
        check("R4 divisor 0 high", hi, 255 * 256);

        done = 1'b1;
        summary();
    end

endmodule